// File: doc/BRIEF.md
# Multi-line PDM microphone receiver

This block clocks up to four pulse-density-modulated data wires from a single generated PDM clock and turns the one-bit streams into 16-bit PCM. Each wire is shared by two microphones that drive it on opposite halves of the clock period. The block therefore has eight capture slots. Slot index `2*line` is the right microphone of a line and `2*line+1` is the left one. A slot mask picks which of the eight streams are delivered. Every slot has its own third-order CIC decimator that runs at a ratio of 64 or 128. At the end of each PCM sample period the block copies the results of all slots into a holding buffer. It then sends the enabled ones out, one at a time, on a valid/ready stream. Each sample carries its line number and its side.

Configuration is static. The divider, the ratio, the stereo/mono choice, the mask and the clock-invert flag may only change while `enable` is low. Dropping `enable` clears all filter state, clears the overflow flag and parks the PDM clock low. The PDM clock is built from two named phases, `PH_LOW` and `PH_HIGH`. The change `PH_LOW -> PH_HIGH` is the internal rising edge, where the right slots sample. The change `PH_HIGH -> PH_LOW` is the internal falling edge, where the left slots sample and the decimation counter advances. The output side is a two-state machine. `SER_IDLE -> SER_SEND` is taken when a sample period ends with a non-empty mask. `SER_SEND -> SER_SEND` is taken on each handshake while enabled slots are still pending. `SER_SEND -> SER_IDLE` is taken on the last handshake, unless a new period ends in that same cycle.

Top module: `pdm_multi_rx`

## Requirements
- R1: During reset, and while `enable` is low, `pdm_clk_o`, `out_valid` and `overflow` are 0, and every filter register is cleared.
- R2: When enabled, each PDM clock half-period lasts `clk_div+1` system cycles (`clk_div` must be at least 3). The pin level is the internal phase XOR `clk_inv`, so with `clk_inv=1` the pin is high in the first cycle after enabling.
- R3: Mask bit 2i enables the right slot of line i and bit 2i+1 enables its left slot. An enabled slot is delivered with `out_line=i` and `out_slot=0` (right) or `out_slot=1` (left).
- R4: In stereo mode (`stereo=1`) a mask of 3 or less acts as 3. Otherwise the mask is used as given, and a mask of 0 in mono mode yields no samples at all.
- R5: Every data line first passes a two-flop synchronizer. A right slot takes the value present at the end of the internal low phase, and a left slot takes the value present at the end of the internal high phase.
- R6: With `clk_inv=0` the right slot holds the bit the line carries while the pin is low. With `clk_inv=1` the two microphones of a line trade places.
- R7: `dsr_mode=0` decimates by 64 and `dsr_mode=1` by 128, so a PCM period lasts `2*(clk_div+1)*64` or `2*(clk_div+1)*128` system cycles.
- R8: Bits map to +1 (1) and -1 (0) and pass through a third-order CIC. The result is shifted right arithmetically by 3 (ratio 64) or 6 (ratio 128) and saturated to signed 16 bits. In steady state, input with a ones density d gives `32768*(2d-1)`, and all ones gives 32767.
- R9: Within a PCM period the samples appear in ascending slot index, which is ascending line with the right slot before the left. Disabled slots are skipped.
- R10: While `out_valid` is high and `out_ready` is low, `out_data`, `out_line` and `out_slot` hold their values.
- R11: If a PCM period ends while the previous period is still being sent, the new period is dropped and the held data stays intact. `overflow` is then set and stays set until `enable` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run; low clears the receiver |
| clk_div | input | 8 | PDM half-period in system cycles, minus one |
| dsr_mode | input | 1 | 0: ratio 64, 1: ratio 128 |
| stereo | input | 1 | Stereo mode; promotes a small mask to 3 |
| slot_mask | input | 8 | Per-line right/left capture enables |
| clk_inv | input | 1 | Invert the PDM clock pin |
| pdm_clk_o | output | 1 | PDM clock to all microphones |
| pdm_data_i | input | 4 | Shared PDM data lines |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts sample |
| out_data | output | 16 | Signed PCM sample |
| out_line | output | 2 | Data line of the sample |
| out_slot | output | 1 | 0 right, 1 left |
| overflow | output | 1 | Sticky: a PCM period was dropped |

## Verification
Each of the eight slots is fed a periodic bit pattern with its own randomly drawn density, so each slot is expected to settle on a different PCM level. A sample with the wrong tag, the wrong side or a swapped polarity therefore shows up as a wrong value, not just as a wrong index. The runs cover the full mask, a masked subset at ratio 128, stereo promotion of a one-bit mask, a mask that stereo mode leaves unchanged, an empty mono mask and a random mask. Inversion is run under random back-pressure, which separates a mix-up of the clock edges from a mix-up of the output order. A directed stall that holds `out_ready` low after the first handshake of a period, for longer than one period, tells a correct drop-and-flag apart from a reload of the buffer: a reload would snap the presented tag back to the first slot.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    localparam int PCM_W = 16;

    // Phase of the internally generated PDM clock
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pdm_phase_t;

    // Output serializer states
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_t;

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
    import pdm_rx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LOG_R = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    input  logic             dsr_mode,
    input  logic             clk_inv,
    output logic             pdm_clk_o,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             frame_ev
);
    localparam int DCNT_W = LOG_R + 1;
    localparam logic [DCNT_W-1:0] LAST_SHORT = DCNT_W'((1 << LOG_R) - 1);
    localparam logic [DCNT_W-1:0] LAST_LONG  = DCNT_W'((1 << (LOG_R + 1)) - 1);

    pdm_phase_t        ph_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic              run_q;
    logic              tick;
    logic [DCNT_W-1:0] last_period;

    assign tick        = enable && (cnt_q == div);
    assign last_period = dsr_mode ? LAST_LONG : LAST_SHORT;

    // Phase state register and half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= PH_LOW;
            cnt_q  <= '0;
            dcnt_q <= '0;
            run_q  <= 1'b0;
        end else if (!enable) begin
            ph_q   <= PH_LOW;
            cnt_q  <= '0;
            dcnt_q <= '0;
            run_q  <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (tick) begin
                cnt_q <= '0;
                unique case (ph_q)
                    PH_LOW:  ph_q <= PH_HIGH;
                    PH_HIGH: begin
                        ph_q   <= PH_LOW;
                        dcnt_q <= (dcnt_q == last_period) ? '0 : dcnt_q + 1'b1;
                    end
                    default: ph_q <= PH_LOW;
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Event outputs
    always_comb begin
        rise_ev   = 1'b0;
        fall_ev   = 1'b0;
        unique case (ph_q)
            PH_LOW:  rise_ev = tick;
            PH_HIGH: fall_ev = tick;
            default: ;
        endcase
        frame_ev  = fall_ev && (dcnt_q == last_period);
        pdm_clk_o = run_q && ((ph_q == PH_HIGH) ^ clk_inv);
    end

    // R2: a phase change only ever follows a full half-period count
    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (ph_q != $past(ph_q))) |-> ($past(cnt_q) == $past(div)));

endmodule

// File: rtl/pdm_cic3.sv
module pdm_cic3
    import pdm_rx_pkg::*;
#(
    parameter int LOG_R = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_ev,
    input  logic             in_bit,
    input  logic             dsr_mode,
    input  logic             dec_ev,
    output logic [PCM_W-1:0] pcm_o
);
    localparam int ACC_W    = 3 * (LOG_R + 1) + 2;
    localparam int SH_SHORT = 3 * LOG_R - (PCM_W - 1);
    localparam int SH_LONG  = 3 * (LOG_R + 1) - (PCM_W - 1);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << (PCM_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] PMIN = ~PMAX;

    logic signed [ACC_W-1:0] x;
    logic signed [ACC_W-1:0] i1_q, i2_q, i3_q;
    logic signed [ACC_W-1:0] d1_q, d2_q, d3_q;
    logic signed [ACC_W-1:0] c1, c2, c3, scaled;
    logic        [PCM_W-1:0] sat;

    always_comb begin
        x      = in_bit ? ACC_W'(1) : '1;
        c1     = i3_q - d1_q;
        c2     = c1 - d2_q;
        c3     = c2 - d3_q;
        scaled = dsr_mode ? (c3 >>> SH_LONG) : (c3 >>> SH_SHORT);
        if (scaled > PMAX)      sat = PMAX[PCM_W-1:0];
        else if (scaled < PMIN) sat = PMIN[PCM_W-1:0];
        else                    sat = scaled[PCM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {i1_q, i2_q, i3_q} <= '0;
            {d1_q, d2_q, d3_q} <= '0;
            pcm_o              <= '0;
        end else if (clr) begin
            {i1_q, i2_q, i3_q} <= '0;
            {d1_q, d2_q, d3_q} <= '0;
            pcm_o              <= '0;
        end else begin
            if (in_ev) begin
                i1_q <= i1_q + x;
                i2_q <= i2_q + i1_q;
                i3_q <= i3_q + i2_q;
            end
            if (dec_ev) begin
                d1_q  <= i3_q;
                d2_q  <= c1;
                d3_q  <= c2;
                pcm_o <= sat;
            end
        end
    end

endmodule

// File: rtl/pdm_out_ser.sv
module pdm_out_ser
    import pdm_rx_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     ld_ev,
    input  logic [SLOTS-1:0]         ld_mask,
    input  logic [SLOTS*PCM_W-1:0]   samples_i,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [PCM_W-1:0]         out_data,
    output logic [$clog2(SLOTS)-1:0] out_idx,
    output logic                     overflow
);
    localparam int IDX_W = $clog2(SLOTS);

    ser_state_t        st_q, st_d;
    logic [SLOTS-1:0]  pend_q;
    logic [PCM_W-1:0]  hold_q [SLOTS];
    logic [IDX_W-1:0]  cur;
    logic              hs, last_hs, free, load;

    always_comb begin
        cur = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (pend_q[k]) cur = IDX_W'(k);
        end
        hs      = (st_q == SER_SEND) && out_ready;
        last_hs = hs && (pend_q == (SLOTS'(1) << cur));
        free    = (st_q == SER_IDLE) || last_hs;
        load    = ld_ev && free && (ld_mask != '0);
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SER_IDLE: if (load) st_d = SER_SEND;
            SER_SEND: if (last_hs && !load) st_d = SER_IDLE;
            default:  st_d = SER_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st_q <= SER_IDLE;
        else if (!enable) st_q <= SER_IDLE;
        else              st_q <= st_d;
    end

    // Pending set and overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            overflow <= 1'b0;
        end else if (!enable) begin
            pend_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (load)    pend_q <= ld_mask;
            else if (hs) pend_q <= pend_q & ~(SLOTS'(1) << cur);
            if (ld_ev && !free) overflow <= 1'b1;
        end
    end

    // Sample buffer, written only when a period is accepted
    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < SLOTS; k++) hold_q[k] <= samples_i[k*PCM_W +: PCM_W];
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (st_q)
            SER_IDLE: out_valid = 1'b0;
            SER_SEND: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
        out_data = hold_q[cur];
        out_idx  = cur;
    end

    // R10: a stalled sample is held
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx)));

    // R11: a period that arrives while busy raises the flag
    a_r11_flag_on_drop: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (out_valid && !out_ready && ld_ev) |=> overflow);

    // R11: the flag is sticky while enabled
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        overflow |=> overflow);

endmodule

// File: rtl/pdm_multi_rx.sv
module pdm_multi_rx
    import pdm_rx_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int DIV_W   = 8,
    parameter int LOG_R   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [DIV_W-1:0]           clk_div,
    input  logic                       dsr_mode,
    input  logic                       stereo,
    input  logic [2*N_LINES-1:0]       slot_mask,
    input  logic                       clk_inv,
    output logic                       pdm_clk_o,
    input  logic [N_LINES-1:0]         pdm_data_i,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [15:0]                out_data,
    output logic [$clog2(N_LINES)-1:0] out_line,
    output logic                       out_slot,
    output logic                       overflow
);
    localparam int SLOTS = 2 * N_LINES;
    localparam int IDX_W = $clog2(SLOTS);

    logic                     rise_ev, fall_ev, frame_ev;
    logic                     dec_q, ld_q;
    logic [N_LINES-1:0]       sync1_q, sync2_q;
    logic [SLOTS-1:0]         eff_mask;
    logic [SLOTS*PCM_W-1:0]   pcm_bus;
    logic [IDX_W-1:0]         out_idx;

    // Stereo promotes a mask confined to line 0 to both of its slots
    assign eff_mask = (stereo && (slot_mask <= SLOTS'(3))) ? SLOTS'(3) : slot_mask;

    pdm_clk_gen #(.DIV_W(DIV_W), .LOG_R(LOG_R)) clk_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .div       (clk_div),
        .dsr_mode  (dsr_mode),
        .clk_inv   (clk_inv),
        .pdm_clk_o (pdm_clk_o),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .frame_ev  (frame_ev)
    );

    // Input synchronizer and period-end pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            dec_q   <= 1'b0;
            ld_q    <= 1'b0;
        end else begin
            sync1_q <= pdm_data_i;
            sync2_q <= sync1_q;
            dec_q   <= enable && frame_ev;
            ld_q    <= enable && dec_q;
        end
    end

    // One decimator per slot: even index samples on the rise, odd on the fall
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic slot_ev;
        if (g % 2 == 0) begin : g_right
            assign slot_ev = rise_ev;
        end else begin : g_left
            assign slot_ev = fall_ev;
        end
        pdm_cic3 #(.LOG_R(LOG_R)) cic_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!enable),
            .in_ev    (slot_ev),
            .in_bit   (sync2_q[g/2]),
            .dsr_mode (dsr_mode),
            .dec_ev   (dec_q),
            .pcm_o    (pcm_bus[g*PCM_W +: PCM_W])
        );
    end

    pdm_out_ser #(.SLOTS(SLOTS)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ld_ev     (ld_q),
        .ld_mask   (eff_mask),
        .samples_i (pcm_bus),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_idx   (out_idx),
        .overflow  (overflow)
    );

    assign out_line = out_idx[IDX_W-1:1];
    assign out_slot = out_idx[0];

    // R1: after enable drops the block goes quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!out_valid && !overflow && !pdm_clk_o));

    // R3 and R4: only slots of the effective mask are ever presented
    a_r3_enabled_slot: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        out_valid |-> eff_mask[{out_line, out_slot}]);

endmodule

// File: tb/pdm_multi_rx_tb.sv
module pdm_multi_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] clk_div = 8'd3;
    logic       dsr_mode = 1'b0;
    logic       stereo = 1'b0;
    logic [7:0] slot_mask = 8'h00;
    logic       clk_inv = 1'b0;
    logic [3:0] pdm_data = 4'h0;
    logic       out_ready = 1'b1;
    logic       pdm_clk_o, out_valid, out_slot, overflow;
    logic [15:0] out_data;
    logic [1:0] out_line;

    pdm_multi_rx dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .dsr_mode(dsr_mode), .stereo(stereo), .slot_mask(slot_mask),
        .clk_inv(clk_inv), .pdm_clk_o(pdm_clk_o), .pdm_data_i(pdm_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_line(out_line), .out_slot(out_slot), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-line densities: kA while the pin is low, kB while it is high
    int kA [NL];
    int kB [NL];

    function automatic logic patbit(input int k, input int c);
        logic [3:0] p;
        case (k)
            0: p = 4'b0000;
            1: p = 4'b0001;
            2: p = 4'b0101;
            3: p = 4'b0111;
            default: p = 4'b1111;
        endcase
        return p[c % 4];
    endfunction

    function automatic int exp_val(input int k);
        return (k >= 4) ? 32767 : 16384 * (k - 2);
    endfunction

    // Microphone model and clock-period measurement
    longint cyc = 0;
    always @(posedge clk) cyc++;

    int lo_c = 0, hi_c = 0;
    logic pin_prev = 1'b0;
    longint last_rise = 0, rise_per = 0;
    always @(negedge clk) begin
        if (pdm_clk_o && !pin_prev) begin
            hi_c++;
            if (last_rise > 0) rise_per = cyc - last_rise;
            last_rise = cyc;
        end
        if (!pdm_clk_o && pin_prev) lo_c++;
        pin_prev = pdm_clk_o;
        for (int i = 0; i < NL; i++)
            pdm_data[i] = pdm_clk_o ? patbit(kB[i], hi_c) : patbit(kA[i], lo_c);
    end

    // Stream monitor (also owns out_ready)
    int order [NS];
    int n_ord = 0, pos = 0, frame_no = 0, n_samp = 0, rdy_mode = 0, exp_period = 0;
    bit per_chk = 0, stall_req = 0, stall_active = 0, mon_inv = 0;
    longint t0_last = 0;
    int held_idx = 0, held_data = 0;

    function automatic int exp_slot(input int idx);
        int ln;
        int k;
        ln = idx / 2;
        if (idx % 2 == 0) k = mon_inv ? kB[ln] : kA[ln];
        else              k = mon_inv ? kA[ln] : kB[ln];
        return exp_val(k);
    endfunction

    always @(negedge clk) begin
        int idx;
        int ev;
        int got;
        if (stall_active) out_ready = 1'b0;
        else if (stall_req && frame_no == 2 && pos == 1 && out_valid) begin
            out_ready    = 1'b0;
            stall_active = 1;
            held_idx     = int'({out_line, out_slot});
            held_data    = int'(out_data);
        end
        else if (rdy_mode == 1) out_ready = 1'($urandom % 2);
        else out_ready = 1'b1;

        if (out_valid && out_ready) begin
            idx = int'({out_line, out_slot});
            got = int'($signed(out_data));
            n_samp++;
            if (n_ord == 0) begin
                check(0, "R4 sample with empty mask", idx, -1);
            end else begin
                check(idx == order[pos], "R9 R3 slot order/tag", idx, order[pos]);
                if (frame_no >= 4) begin
                    ev = exp_slot(idx);
                    check(got == ev, "R8 R5 R6 PCM value", got, ev);
                end
                if (pos == 0) begin
                    if (per_chk && frame_no >= 1)
                        check((cyc - t0_last) == longint'(exp_period), "R7 period length",
                              int'(cyc - t0_last), exp_period);
                    t0_last = cyc;
                end
                pos++;
                if (pos == n_ord) begin
                    pos = 0;
                    frame_no++;
                end
            end
        end
    end

    task automatic run_cfg(input logic [7:0] m, input bit st, input bit md, input bit inv,
                           input int dv, input int rm, input int nfr, input bit stall);
        logic [7:0] eff;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        slot_mask = m; stereo = st; dsr_mode = md; clk_inv = inv; clk_div = 8'(dv);
        mon_inv = inv; rdy_mode = rm; per_chk = (rm == 0) && !stall;
        for (int i = 0; i < NL; i++) begin
            kA[i] = int'($urandom % 5);
            kB[i] = int'($urandom % 5);
        end
        eff = (st && m <= 8'h03) ? 8'h03 : m;
        n_ord = 0;
        for (int k = 0; k < NS; k++) if (eff[k]) begin order[n_ord] = k; n_ord++; end
        pos = 0; frame_no = 0; n_samp = 0; stall_req = stall; stall_active = 0;
        last_rise = 0; rise_per = 0;
        exp_period = 2 * (dv + 1) * (md ? 128 : 64);
        enable = 1'b1;
        @(negedge clk);
        check(pdm_clk_o == inv, "R2 pin polarity after enable", int'(pdm_clk_o), int'(inv));
        if (stall) begin
            while (!stall_active) @(negedge clk);
            repeat (700) @(negedge clk);
            check(overflow == 1'b1, "R11 overflow on dropped period", int'(overflow), 1);
            check(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
            check(int'({out_line, out_slot}) == held_idx, "R10 R11 held tag",
                  int'({out_line, out_slot}), held_idx);
            check(int'(out_data) == held_data, "R10 R11 held data", int'(out_data), held_data);
            stall_active = 0;
            stall_req = 0;
            repeat (2 * exp_period) @(negedge clk);
            check(overflow == 1'b1, "R11 overflow sticky", int'(overflow), 1);
            check(frame_no >= 3, "R11 stream resumes", frame_no, 3);
        end else begin
            repeat (nfr * exp_period + exp_period / 2) @(negedge clk);
            check(rise_per == longint'(2 * (dv + 1)), "R2 PDM clock period", int'(rise_per), 2 * (dv + 1));
            if (n_ord == 0) check(n_samp == 0, "R4 no samples for empty mono mask", n_samp, 0);
            else            check(frame_no == nfr, "R7 periods delivered", frame_no, nfr);
        end
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!overflow && !pdm_clk_o && !out_valid, "R1 quiet after disable",
              int'({overflow, pdm_clk_o, out_valid}), 0);
    endtask

    initial begin
        void'($urandom(32'd20221104));
        for (int i = 0; i < NL; i++) begin kA[i] = 0; kB[i] = 0; end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!pdm_clk_o && !out_valid && !overflow, "R1 reset state",
              int'({pdm_clk_o, out_valid, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_cfg(8'hFF, 1, 0, 0, 3, 0, 7, 0);   // all slots, ratio 64
        run_cfg(8'hFF, 1, 0, 1, 3, 1, 7, 0);   // R6 inverted, random ready
        run_cfg(8'h5A, 0, 1, 0, 4, 0, 6, 0);   // R7 ratio 128, subset
        run_cfg(8'h01, 1, 0, 0, 3, 0, 6, 0);   // R4 stereo promotion
        run_cfg(8'h05, 1, 0, 0, 3, 1, 6, 0);   // R4 mask kept as given
        run_cfg(8'h00, 0, 0, 0, 3, 0, 4, 0);   // R4 empty mono mask
        run_cfg(8'(($urandom % 255) + 1), 0, 0, 0, 5, 1, 6, 0);
        run_cfg(8'hFF, 1, 0, 0, 3, 0, 8, 1);   // R11 stall and drop
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule